// File: doc/BRIEF.md
# Oversampled Serial Receiver with Infrared Pulse Decoding

This block receives asynchronous serial frames on a single raw input line. A one-cycle oversampling strobe, sixteen per bit time, paces all sampling. The baud-rate divider that produces this strobe sits outside the block. The line passes through a synchronizer and an optional level inverter. An optional infrared-style pulse decoder then converts it into plain NRZ levels, where high means logic one. A bit engine hunts for a start bit, confirms it by majority vote, and gathers 8 or 9 data bits least significant first. It then checks the stop bit.

Each received word is presented with a one-cycle valid strobe. In 9-bit mode the ninth bit is carried on its own output pin. A frame-error level is updated together with each word. A receiver-busy flag shows when a reception is under way. A one-cycle idle strobe marks a full frame time of continuous ones. Parity, bus access, interrupts and queuing belong to the surrounding logic.

Top module: `uart_irda_rx`

## Requirements
- R1: While reset is asserted and right after its release, `rx_valid`, `rx_active`, `rx_frame_err`, `rx_idle`, `rx_bit8` and `rx_data` are all 0.
- R2: With `cfg_invert`=0 and `cfg_irda`=0, a high line is a one and a low line is a zero. With `cfg_invert`=1 these two meanings swap.
- R3: A frame is one start zero, then the data bits least significant first, then a stop bit. When it ends, `rx_valid` pulses for one clock cycle with the data on `rx_data`. In 8-bit mode (`cfg_nine`=0) `rx_bit8` is 0.
- R4: With `cfg_nine`=1 the frame carries nine data bits. The first eight appear on `rx_data[7:0]` and the ninth on `rx_bit8`.
- R5: The first zero sample found while searching is called RT1. A start bit is accepted only if at least two of the samples RT3, RT5 and RT7 are zero. Otherwise no word is delivered and `rx_active` returns to 0.
- R6: Each data bit and the stop bit are decided by a two-of-three vote over samples RT8, RT9 and RT10 of that bit. A single deviating sample does not change the bit.
- R7: If the stop bit votes zero, `rx_frame_err` is 1 when the word is delivered. If the stop bit votes one, it is 0. `rx_frame_err` changes only when `rx_valid` is high.
- R8: `rx_active` rises on the clock after the RT1 sample of a start-bit search. It stays high through the whole frame.
- R9: `rx_idle` pulses for one cycle once the line has been one for 160 consecutive samples (`cfg_nine`=0) or 176 (`cfg_nine`=1). A pulse clears `rx_active`. There is no second pulse until a zero is sampled.
- R10: With `cfg_irda`=1 and `cfg_invert`=0, a line that stays low for a bit time is a one. A high pulse of at least one sample inside the bit time is a zero.
- R11: With `cfg_irda`=1 and `cfg_invert`=1, a line that stays high for a bit time is a one. A low pulse inside the bit time is a zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time, one cycle wide |
| rxd_in | input | 1 | Raw serial line (asynchronous) |
| cfg_invert | input | 1 | 0 normal line polarity, 1 inverted |
| cfg_irda | input | 1 | 0 NRZ line, 1 pulse-coded line |
| cfg_nine | input | 1 | 0 eight data bits, 1 nine data bits |
| rx_data | output | 8 | Lower eight bits of the received word |
| rx_bit8 | output | 1 | Ninth received bit (9-bit mode) |
| rx_valid | output | 1 | One-cycle strobe: new word present |
| rx_frame_err | output | 1 | Stop bit of the last word was zero |
| rx_active | output | 1 | Reception in progress |
| rx_idle | output | 1 | One-cycle strobe: idle frame seen |

## Verification
The bench builds the block with its defaults: 16 samples per bit and a two-stage synchronizer. It feeds the strobe every fourth clock, so each bit spans 64 clocks. Inputs change well clear of every sample, which lets the bench place a single-sample glitch exactly on RT9 of a chosen bit. It can also place a false start that is low only for RT1 and RT2. Across the 8-bit and 9-bit settings, the idle count limit can be checked to the exact sample (160 versus 176). The pulse decoder's stretch window is exercised in both polarities and in 9-bit mode.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_START  = 2'd1,
    ST_DATA   = 2'd2,
    ST_STOP   = 2'd3
  } rx_state_e;

  // two-of-three vote
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  input  logic invert_i,
  input  logic irda_i,
  output logic line_o
);

  localparam int SW = $clog2(OVS + 1);
  localparam logic [SW-1:0] STRETCH = SW'(OVS);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SW-1:0]          hold_q, hold_d;
  logic                   lvl;

  // synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      assign sync_d = raw_i;
    end else begin : g_syncn
      assign sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1] ^ invert_i;

  // pulse stretcher: a sampled pulse holds a zero for one bit time
  always_comb begin
    hold_d = hold_q;
    if (tick_i) begin
      if (irda_i && lvl)
        hold_d = STRETCH;
      else if (hold_q != '0)
        hold_d = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hold_q <= '0;
    end else begin
      sync_q <= sync_d;
      hold_q <= hold_d;
    end
  end

  assign line_o = irda_i ? (hold_q == '0) : lvl;

  // a sampled pulse must show as zero on the following cycle
  p_pulse_decodes_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && irda_i && lvl) |=> (!irda_i || !line_o));

endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  input  logic nine_i,
  output logic idle_o
);

  localparam int CW = $clog2(11 * OVS + 1);
  localparam logic [CW-1:0] LIM8 = CW'(10 * OVS);
  localparam logic [CW-1:0] LIM9 = CW'(11 * OVS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          idle_q, idle_d;
  logic [CW-1:0] limit;

  assign limit = nine_i ? LIM9 : LIM8;

  always_comb begin
    cnt_d  = cnt_q;
    idle_d = 1'b0;
    if (tick_i) begin
      if (!line_i) begin
        cnt_d = '0;
      end else if (cnt_q < limit) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == limit - 1'b1)
          idle_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
    end
  end

  assign idle_o = idle_q;

  p_idle_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |=> !idle_o);

  p_idle_needs_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !line_i) |=> !idle_o);

endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          nine_i,
  input  logic          idle_i,
  output logic [DW-1:0] word_o,
  output logic          valid_o,
  output logic          ferr_o,
  output logic          active_o
);

  localparam int RW  = $clog2(OVS + 1);
  localparam int BW  = $clog2(DW + 1);
  localparam int MID = OVS / 2;
  localparam logic [RW-1:0] RT_Q0 = RW'((3 * OVS) / 16);
  localparam logic [RW-1:0] RT_Q1 = RW'((5 * OVS) / 16);
  localparam logic [RW-1:0] RT_Q2 = RW'((7 * OVS) / 16);
  localparam logic [RW-1:0] RT_V0 = RW'(MID);
  localparam logic [RW-1:0] RT_V1 = RW'(MID + 1);
  localparam logic [RW-1:0] RT_V2 = RW'(MID + 2);
  localparam logic [RW-1:0] RT_END = RW'(OVS);
  localparam logic [BW-1:0] LAST9 = BW'(DW - 1);
  localparam logic [BW-1:0] LAST8 = BW'(DW - 2);

  rx_state_e     state_q, state_d;
  logic [RW-1:0] rt_q, rt_d, rt_cur;
  logic [BW-1:0] bidx_q, bidx_d;
  logic [1:0]    vote_q, vote_d;
  logic [DW-1:0] shf_q, shf_d;
  logic [DW-1:0] word_q, word_d;
  logic          valid_q, valid_d;
  logic          ferr_q, ferr_d;
  logic          act_q, act_d;
  logic          start_seen;
  logic          bit_val;

  assign rt_cur     = rt_q + 1'b1;
  assign start_seen = tick_i && (state_q == ST_SEARCH) && !line_i;
  assign bit_val    = vote3(vote_q[0], vote_q[1], line_i);

  always_comb begin
    state_d = state_q;
    rt_d    = rt_q;
    bidx_d  = bidx_q;
    vote_d  = vote_q;
    shf_d   = shf_q;
    word_d  = word_q;
    valid_d = 1'b0;
    ferr_d  = ferr_q;
    act_d   = act_q;

    if (idle_i)
      act_d = 1'b0;

    if (tick_i) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (!line_i) begin
            state_d = ST_START;
            rt_d    = RW'(1);
            act_d   = 1'b1;
          end
        end
        ST_START: begin
          rt_d = rt_cur;
          if (rt_cur == RT_Q0) vote_d[0] = line_i;
          if (rt_cur == RT_Q1) vote_d[1] = line_i;
          if (rt_cur == RT_Q2 && bit_val) begin
            state_d = ST_SEARCH;
            rt_d    = '0;
            act_d   = 1'b0;
          end
          if (rt_cur == RT_END) begin
            state_d = ST_DATA;
            rt_d    = '0;
            bidx_d  = '0;
          end
        end
        ST_DATA: begin
          rt_d = rt_cur;
          if (rt_cur == RT_V0) vote_d[0] = line_i;
          if (rt_cur == RT_V1) vote_d[1] = line_i;
          if (rt_cur == RT_V2) shf_d = {bit_val, shf_q[DW-1:1]};
          if (rt_cur == RT_END) begin
            rt_d = '0;
            if (bidx_q == (nine_i ? LAST9 : LAST8))
              state_d = ST_STOP;
            else
              bidx_d = bidx_q + 1'b1;
          end
        end
        ST_STOP: begin
          rt_d = rt_cur;
          if (rt_cur == RT_V0) vote_d[0] = line_i;
          if (rt_cur == RT_V1) vote_d[1] = line_i;
          if (rt_cur == RT_V2) begin
            ferr_d  = !bit_val;
            word_d  = nine_i ? shf_q : {1'b0, shf_q[DW-1:1]};
            valid_d = 1'b1;
            state_d = ST_SEARCH;
            rt_d    = '0;
          end
        end
        default: state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      rt_q    <= '0;
      bidx_q  <= '0;
      vote_q  <= '0;
      shf_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rt_q    <= rt_d;
      bidx_q  <= bidx_d;
      vote_q  <= vote_d;
      shf_q   <= shf_d;
      word_q  <= word_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
      act_q   <= act_d;
    end
  end

  assign word_o   = word_q;
  assign valid_o  = valid_q;
  assign ferr_o   = ferr_q;
  assign active_o = act_q;

  p_valid_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_ferr_only_with_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(ferr_o));

  p_false_start_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && state_q == ST_START && rt_cur == RT_Q2 && bit_val)
      |=> (state_q == ST_SEARCH && !active_o));

  p_active_on_rt1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> active_o);

  p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !start_seen) |=> !active_o);

  p_word_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> active_o);

endmodule

// File: rtl/uart_irda_rx.sv
module uart_irda_rx #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd_in,
  input  logic       cfg_invert,
  input  logic       cfg_irda,
  input  logic       cfg_nine,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_valid,
  output logic       rx_frame_err,
  output logic       rx_active,
  output logic       rx_idle
);

  localparam int DW = 9;

  logic          line_nrz;
  logic          idle_pulse;
  logic [DW-1:0] word;

  rx_line_cond #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick16),
    .raw_i    (rxd_in),
    .invert_i (cfg_invert),
    .irda_i   (cfg_irda),
    .line_o   (line_nrz)
  );

  rx_idle_det #(.OVS(OVS)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick16),
    .line_i (line_nrz),
    .nine_i (cfg_nine),
    .idle_o (idle_pulse)
  );

  rx_bit_engine #(.OVS(OVS), .DW(DW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick16),
    .line_i   (line_nrz),
    .nine_i   (cfg_nine),
    .idle_i   (idle_pulse),
    .word_o   (word),
    .valid_o  (rx_valid),
    .ferr_o   (rx_frame_err),
    .active_o (rx_active)
  );

  assign rx_data = word[7:0];
  assign rx_bit8 = word[8];
  assign rx_idle = idle_pulse;

  p_no_bit8_in_8bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_nine) |-> !rx_bit8);

endmodule

// File: tb/uart_irda_rx_test.sv
module uart_irda_rx_test;

  localparam int OVS = 16;

  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       rxd_in;
  logic       cfg_invert;
  logic       cfg_irda;
  logic       cfg_nine;
  logic [7:0] rx_data;
  logic       rx_bit8;
  logic       rx_valid;
  logic       rx_frame_err;
  logic       rx_active;
  logic       rx_idle;

  uart_irda_rx uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick16       (tick16),
    .rxd_in       (rxd_in),
    .cfg_invert   (cfg_invert),
    .cfg_irda     (cfg_irda),
    .cfg_nine     (cfg_nine),
    .rx_data      (rx_data),
    .rx_bit8      (rx_bit8),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .rx_active    (rx_active),
    .rx_idle      (rx_idle)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // oversampling strobe: one clock in four
  logic [1:0] div = 2'd0;
  initial tick16 = 1'b0;
  always @(posedge clk) begin
    div    <= div + 2'd1;
    tick16 <= (div == 2'd3);
  end

  // observation of outputs
  int         tick_no  = 0;
  int         got_n    = 0;
  int         idle_n   = 0;
  int         idle_at  = 0;
  logic [7:0] got_data = 8'h00;
  logic       got_b8   = 1'b0;
  logic       got_fe   = 1'b0;
  always @(posedge clk) begin
    if (tick16) tick_no <= tick_no + 1;
    if (rx_valid) begin
      got_n    <= got_n + 1;
      got_data <= rx_data;
      got_b8   <= rx_bit8;
      got_fe   <= rx_frame_err;
    end
    if (rx_idle) begin
      idle_n  <= idle_n + 1;
      idle_at <= tick_no;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
    @(negedge clk);
  endtask

  // NRZ frame; glitch[i] flips the level of bit i for one sample at RT9
  task automatic send_nrz(input logic [8:0] w, input int nbits, input logic stop, input logic [8:0] glitch);
    rxd_in = 1'b0 ^ cfg_invert;
    wait_ticks(OVS);
    for (int i = 0; i < nbits; i++) begin
      rxd_in = w[i] ^ cfg_invert;
      if (glitch[i]) begin
        wait_ticks(8);
        rxd_in = ~rxd_in;
        wait_ticks(1);
        rxd_in = ~rxd_in;
        wait_ticks(OVS - 9);
      end else begin
        wait_ticks(OVS);
      end
    end
    rxd_in = stop ^ cfg_invert;
    wait_ticks(OVS);
    rxd_in = 1'b1 ^ cfg_invert;
  endtask

  task automatic irda_bit(input logic b);
    rxd_in = cfg_invert;
    if (b) begin
      wait_ticks(OVS);
    end else begin
      wait_ticks(6);
      rxd_in = ~cfg_invert;
      wait_ticks(3);
      rxd_in = cfg_invert;
      wait_ticks(OVS - 9);
    end
  endtask

  task automatic send_irda(input logic [8:0] w, input int nbits);
    irda_bit(1'b0);
    for (int i = 0; i < nbits; i++) irda_bit(w[i]);
    irda_bit(1'b1);
    rxd_in = cfg_invert;
  endtask

  task automatic wait_word(input int n0);
    for (int i = 0; i < 30 && got_n == n0; i++) wait_ticks(1);
  endtask

  task automatic expect_word(input string req, input int n0, input int d, input int b8, input int fe);
    wait_word(n0);
    chk(req, "word count", got_n, n0 + 1);
    chk(req, "data", int'(got_data), d);
    chk(req, "bit8", int'(got_b8), b8);
    chk(req, "frame_err", int'(got_fe), fe);
  endtask

  task automatic set_mode(input logic inv, input logic irda, input logic nine);
    cfg_invert = inv;
    cfg_irda   = irda;
    cfg_nine   = nine;
    rxd_in     = irda ? inv : ~inv;
    wait_ticks(200);
  endtask

  task automatic t_reset();
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "rx_active", int'(rx_active), 0);
    chk("R1", "rx_frame_err", int'(rx_frame_err), 0);
    chk("R1", "rx_idle", int'(rx_idle), 0);
    chk("R1", "rx_data", int'(rx_data), 0);
    chk("R1", "rx_bit8", int'(rx_bit8), 0);
  endtask

  task automatic t_nrz_polarity();
    int n0;
    set_mode(1'b0, 1'b0, 1'b0);
    n0 = got_n;
    send_nrz(9'h0A5, 8, 1'b1, 9'h000);
    expect_word("R3", n0, 8'hA5, 0, 0);
    set_mode(1'b1, 1'b0, 1'b0);
    n0 = got_n;
    send_nrz(9'h03C, 8, 1'b1, 9'h000);
    expect_word("R2", n0, 8'h3C, 0, 0);
  endtask

  task automatic t_nine_bit();
    int n0;
    set_mode(1'b0, 1'b0, 1'b1);
    n0 = got_n;
    send_nrz(9'h1C3, 9, 1'b1, 9'h000);
    expect_word("R4", n0, 8'hC3, 1, 0);
    wait_ticks(20);
    n0 = got_n;
    send_nrz(9'h0AA, 9, 1'b1, 9'h000);
    expect_word("R4", n0, 8'hAA, 0, 0);
  endtask

  task automatic t_glitch();
    int n0;
    set_mode(1'b0, 1'b0, 1'b0);
    n0 = got_n;
    send_nrz(9'h081, 8, 1'b1, 9'h003);
    expect_word("R6", n0, 8'h81, 0, 0);
  endtask

  task automatic t_frame_err();
    int n0;
    set_mode(1'b0, 1'b0, 1'b0);
    n0 = got_n;
    send_nrz(9'h05A, 8, 1'b0, 9'h000);
    expect_word("R7", n0, 8'h5A, 0, 1);
    wait_ticks(300);
    n0 = got_n;
    send_nrz(9'h0C6, 8, 1'b1, 9'h000);
    expect_word("R7", n0, 8'hC6, 0, 0);
  endtask

  task automatic t_false_start();
    int n0;
    set_mode(1'b0, 1'b0, 1'b0);
    chk("R9", "active before start", int'(rx_active), 0);
    n0 = got_n;
    rxd_in = 1'b0;
    wait_ticks(2);
    chk("R8", "active at RT1", int'(rx_active), 1);
    rxd_in = 1'b1;
    wait_ticks(14);
    chk("R5", "active after rejected start", int'(rx_active), 0);
    wait_ticks(200);
    chk("R5", "no word from rejected start", got_n, n0);
  endtask

  task automatic t_active_idle();
    int n0, i0;
    set_mode(1'b0, 1'b0, 1'b0);
    n0 = got_n;
    rxd_in = 1'b0;
    wait_ticks(3);
    chk("R8", "active in start bit", int'(rx_active), 1);
    rxd_in = 1'b1;
    wait_ticks(OVS - 3);
    rxd_in = 1'b0;
    wait_ticks(8 * OVS);
    rxd_in = 1'b1;
    wait_ticks(OVS);
    wait_word(n0);
    chk("R8", "active after word", int'(rx_active), 1);
    i0 = idle_n;
    wait_ticks(170);
    chk("R9", "idle pulses", idle_n, i0 + 1);
    chk("R9", "active after idle", int'(rx_active), 0);
  endtask

  task automatic idle_span(input logic nine, input int exp);
    int mark, i0;
    set_mode(1'b0, 1'b0, nine);
    rxd_in = 1'b0;
    wait_ticks(2);
    rxd_in = 1'b1;
    mark = tick_no;
    i0 = idle_n;
    wait_ticks(exp + 30);
    chk("R9", "idle pulse count", idle_n, i0 + 1);
    chk("R9", "idle distance in samples", idle_at - mark, exp);
  endtask

  task automatic t_irda();
    int n0;
    set_mode(1'b0, 1'b1, 1'b0);
    n0 = got_n;
    send_irda(9'h096, 8);
    expect_word("R10", n0, 8'h96, 0, 0);
    set_mode(1'b1, 1'b1, 1'b0);
    n0 = got_n;
    send_irda(9'h04B, 8);
    expect_word("R11", n0, 8'h4B, 0, 0);
    set_mode(1'b0, 1'b1, 1'b1);
    n0 = got_n;
    send_irda(9'h1E7, 9);
    expect_word("R10", n0, 8'hE7, 1, 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    rxd_in     = 1'b1;
    cfg_invert = 1'b0;
    cfg_irda   = 1'b0;
    cfg_nine   = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nrz_polarity();
    t_nine_bit();
    t_glitch();
    t_frame_err();
    t_false_start();
    t_active_idle();
    idle_span(1'b0, 10 * OVS);
    idle_span(1'b1, 11 * OVS);
    t_irda();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule